// File: doc/BRIEF.md
# Shared Bus Ownership Requester

This block wins and keeps ownership of a backplane bus that several boards share and a central arbiter controls. Two local agents use it: a master interface that runs data cycles, and an interrupt-acknowledge engine. When either agent needs the bus, the block drives one of four bus-request lines. The line is chosen by a configuration field. The block then waits for the arbiter's grant on that line. Grants arrive through a daisy chain. The block absorbs a grant while it is requesting and forwards every other grant down the chain unchanged.

Once granted, the block asserts bus-busy, drops its request and raises a registered owner flag. While the owner flag is up, a local agent that is asking is granted; the master wins when both ask. Bus-busy stays up for at least a minimum number of clocks. After that, the release policy decides when the bus is let go. In release-when-done, the bus is freed as soon as no local agent needs it. In release-on-request, the bus is freed only once no local agent needs it and another board drives any request line. A fair option stops a new request while another board holds the chosen line. A lock input stops every release.

Top module: `bus_requester`

## Requirements
- R1: If the master or the interrupt-acknowledge agent asks while the block is idle, and fair mode does not block it, the request output is asserted after the next clock edge. It stays asserted until a grant arrives on the chosen level.
- R2: The request output is one-hot: bit `cfg_level` is set while requesting, and every bit is 0 otherwise.
- R3: While requesting, `bg_out[cfg_level]` is forced to 0 (the grant is absorbed). At all other times, and on every other level, `bg_out` equals `bg_in` in the same cycle.
- R4: If `bg_in[cfg_level]` is high at a clock edge while requesting, then after that edge `bbsy_out` and `owner` are 1 and the request output is all zeros.
- R5: Once raised, `bbsy_out` stays high for at least MIN_BUSY consecutive cycles (default 4).
- R6: With `cfg_ror`=0 (release-when-done), the bus is released at the first edge where the minimum hold has elapsed, `lock` is 0 and both agent requests are 0.
- R7: With `cfg_ror`=1 (release-on-request), the conditions of R6 must hold and, in addition, at least one bit of `br_in` must be 1. Without that, ownership is kept indefinitely.
- R8: With `cfg_fair`=1, no new request is raised while `br_in[cfg_level]` is 1. After the line clears, a pending need raises the request at the next edge.
- R9: While `lock` is 1, the owned bus is never released in either release mode.
- R10: `mst_gnt` = owner AND `mst_req`; `iack_gnt` = owner AND `iack_req` AND NOT `mst_req`. Both are 0 when the block does not own the bus.
- R11: After reset, the block is idle: `br_out`=0, `bbsy_out`=0, `owner`=0, both local grants 0, and `bg_out`=`bg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_level | input | 2 | Selected request/grant level |
| cfg_ror | input | 1 | 1 = release-on-request, 0 = release-when-done |
| cfg_fair | input | 1 | Fair request throttling enable |
| lock | input | 1 | Hold ownership, never release |
| mst_req | input | 1 | Master interface needs the bus |
| iack_req | input | 1 | Interrupt-acknowledge engine needs the bus |
| mst_gnt | output | 1 | Master may run its cycle |
| iack_gnt | output | 1 | Interrupt-acknowledge engine may run its cycle |
| owner | output | 1 | Registered bus-ownership flag |
| br_in | input | 4 | Request lines driven by other boards |
| br_out | output | 4 | This block's request lines |
| bg_in | input | 4 | Incoming daisy-chain grants |
| bg_out | output | 4 | Outgoing daisy-chain grants |
| bbsy_out | output | 1 | Bus-busy while owning |

## Verification
Some results settle in the same cycle as the inputs that cause them, with no clock edge in between: grant forwarding and absorption, and the local grants from the current owner flag and agent requests. Two results appear one edge after their cause. The request line rises one edge after a need is seen, and busy/owner rise one edge after a grant is sampled. Release also happens one edge after the release condition holds, and the hold count is MIN_BUSY edges from the grant. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a model. That model is advanced only at the rising edge, using the inputs that were stable before it. Directed checks count exact busy cycles for the minimum hold, and watch long windows for the lock, release-on-request and fair cases.

// File: rtl/bus_requester.sv
module bus_requester #(
  parameter int NLINES   = 4,
  parameter int MIN_BUSY = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NLINES)-1:0] cfg_level,
  input  logic                      cfg_ror,
  input  logic                      cfg_fair,
  input  logic                      lock,
  input  logic                      mst_req,
  input  logic                      iack_req,
  output logic                      mst_gnt,
  output logic                      iack_gnt,
  output logic                      owner,
  input  logic [NLINES-1:0]         br_in,
  output logic [NLINES-1:0]         br_out,
  input  logic [NLINES-1:0]         bg_in,
  output logic [NLINES-1:0]         bg_out,
  output logic                      bbsy_out
);
  localparam int CW = $clog2(MIN_BUSY + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_OWN} st_t;

  st_t             st;
  logic [CW-1:0]   hold;
  logic [NLINES-1:0] sel;
  logic            need, blocked, held, rel_ok;

  assign sel     = NLINES'(1) << cfg_level;
  assign need    = mst_req | iack_req;
  assign blocked = cfg_fair & br_in[cfg_level];
  assign held    = (hold == CW'(MIN_BUSY));
  assign rel_ok  = held & ~lock & ~need & (~cfg_ror | (|br_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (need && !blocked) st <= S_REQ;
        S_REQ:  if (bg_in[cfg_level]) begin
                  st   <= S_OWN;
                  hold <= CW'(1);
                end
        S_OWN: begin
          if (!held) hold <= hold + CW'(1);
          if (rel_ok) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign owner    = (st == S_OWN);
  assign bbsy_out = owner;
  assign br_out   = (st == S_REQ) ? sel : '0;
  assign bg_out   = bg_in & ~br_out;
  assign mst_gnt  = owner & mst_req;
  assign iack_gnt = owner & iack_req & ~mst_req;
endmodule

// File: rtl/bus_requester_chk.sv
module bus_requester_chk #(
  parameter int NLINES   = 4,
  parameter int MIN_BUSY = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [$clog2(NLINES)-1:0] cfg_level,
  input logic                      cfg_ror,
  input logic                      cfg_fair,
  input logic                      lock,
  input logic                      mst_req,
  input logic                      iack_req,
  input logic                      mst_gnt,
  input logic                      iack_gnt,
  input logic                      owner,
  input logic [NLINES-1:0]         br_in,
  input logic [NLINES-1:0]         br_out,
  input logic [NLINES-1:0]         bg_in,
  input logic [NLINES-1:0]         bg_out,
  input logic                      bbsy_out
);
  localparam int CW = $clog2(MIN_BUSY + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!bbsy_out) run <= '0;
    else if (run != CW'(MIN_BUSY)) run <= run + CW'(1);
  end

  a_r2_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_out));
  a_r3_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    (|br_out) |-> (bg_out[cfg_level] == 1'b0));
  a_r4_no_req_when_owning: assert property (@(posedge clk) disable iff (!rst_n)
    bbsy_out |-> (br_out == '0));
  a_r4_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    ((|br_out) && bg_in[cfg_level]) |=> (owner && bbsy_out));
  a_r5_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bbsy_out) |-> (run == CW'(MIN_BUSY)));
  a_r8_fair_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fair && br_in[cfg_level] && br_out == '0) |=> (br_out == '0));
  a_r9_lock_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && bbsy_out) |=> bbsy_out);
  a_r10_local_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_gnt || iack_gnt) |-> (owner && !(mst_gnt && iack_gnt)));
endmodule

bind bus_requester bus_requester_chk #(.NLINES(NLINES), .MIN_BUSY(MIN_BUSY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_ror(cfg_ror),
  .cfg_fair(cfg_fair), .lock(lock), .mst_req(mst_req), .iack_req(iack_req),
  .mst_gnt(mst_gnt), .iack_gnt(iack_gnt), .owner(owner), .br_in(br_in),
  .br_out(br_out), .bg_in(bg_in), .bg_out(bg_out), .bbsy_out(bbsy_out));

// File: tb/bus_requester_tb.sv
module bus_requester_tb;
  localparam int MINB = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_level = 0;
  logic cfg_ror = 0, cfg_fair = 0, lock = 0, mst_req = 0, iack_req = 0;
  logic mst_gnt, iack_gnt, owner, bbsy_out;
  logic [3:0] br_in = 0, br_out, bg_in = 0, bg_out;

  int n_chk = 0, n_fail = 0;
  int m_st = 0, m_cnt = 0;

  always #5 clk = ~clk;

  bus_requester #(.NLINES(4), .MIN_BUSY(MINB)) u_dut (.*);

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] e_br();
    return (m_st == 1) ? (4'b1 << cfg_level) : 4'b0;
  endfunction

  // Compare all outputs, then advance the model at the rising edge.
  task automatic step();
    logic [3:0] eb;
    bit eo, need;
    #1;
    eb = e_br();
    eo = (m_st == 2);
    chk(br_out == eb, "R1/R2 br_out", br_out, eb);
    chk(bg_out == (bg_in & ~eb), "R3 bg_out", bg_out, bg_in & ~eb);
    chk(bbsy_out == eo && owner == eo, "R4 busy/owner", {bbsy_out, owner}, {eo, eo});
    chk(mst_gnt == (eo & mst_req) && iack_gnt == (eo & iack_req & ~mst_req),
        "R10 local grants", {mst_gnt, iack_gnt}, {eo & mst_req, eo & iack_req & ~mst_req});
    need = mst_req | iack_req;
    @(posedge clk);
    case (m_st)
      0: if (need && !(cfg_fair && br_in[cfg_level])) m_st = 1;
      1: if (bg_in[cfg_level]) begin m_st = 2; m_cnt = 1; end
      default: begin
        if (m_cnt >= MINB && !lock && !need && (!cfg_ror || (|br_in))) m_st = 0;
        else if (m_cnt < MINB) m_cnt++;
      end
    endcase
    @(negedge clk);
  endtask

  task automatic win_bus();
    mst_req = 1; bg_in = 0;
    step();
    bg_in = 4'b1 << cfg_level;
    step();
    bg_in = 0;
  endtask

  initial begin
    int busy;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R11 reset state
    bg_in = 4'b1010;
    #1;
    chk(br_out == 0 && bbsy_out == 0 && owner == 0 && !mst_gnt && !iack_gnt,
        "R11 reset outputs", {br_out, bbsy_out, owner}, 0);
    chk(bg_out == 4'b1010, "R11 reset grant pass", bg_out, 4'b1010);
    @(negedge clk); rst_n = 1; bg_in = 0;
    step();

    // R5 R6: release-when-done holds exactly MIN_BUSY cycles
    cfg_level = 2; cfg_ror = 0;
    win_bus();
    mst_req = 0; busy = 0;
    for (int i = 0; i < 12; i++) begin if (bbsy_out) busy++; step(); end
    chk(busy == MINB, "R5 R6 minimum busy then release", busy, MINB);

    // R7: release-on-request keeps bus without other requests
    cfg_ror = 1; cfg_level = 1;
    win_bus();
    mst_req = 0;
    for (int i = 0; i < 20; i++) step();
    chk(bbsy_out == 1, "R7 kept with no other request", bbsy_out, 1);
    br_in = 4'b1000;
    step(); step();
    chk(bbsy_out == 0, "R7 released on foreign request", bbsy_out, 0);
    br_in = 0; step();

    // R9: lock prevents release in both modes
    for (int m = 0; m < 2; m++) begin
      cfg_ror = m[0];
      win_bus();
      lock = 1; mst_req = 0; br_in = 4'b0101;
      for (int i = 0; i < 30; i++) step();
      chk(bbsy_out == 1, "R9 lock holds bus", bbsy_out, 1);
      lock = 0; step(); step();
      chk(bbsy_out == 0, "R9 release after unlock", bbsy_out, 0);
      br_in = 0; step();
    end

    // R8: fair mode waits for the chosen line to clear
    cfg_fair = 1; cfg_level = 3; br_in = 4'b1000; iack_req = 1;
    for (int i = 0; i < 10; i++) step();
    chk(br_out == 0, "R8 fair blocks request", br_out, 0);
    br_in = 0; step();
    chk(br_out == 4'b1000, "R8 request after line clears", br_out, 4'b1000);
    bg_in = 4'b1000; step(); bg_in = 0;
    chk(iack_gnt == 1, "R10 iack granted when alone", iack_gnt, 1);
    mst_req = 1; #1;
    chk(mst_gnt == 1 && iack_gnt == 0, "R10 master priority", {mst_gnt, iack_gnt}, 2'b10);
    mst_req = 0; iack_req = 0; cfg_fair = 0; cfg_ror = 0;
    for (int i = 0; i < 6; i++) step();

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0 && m_st != 1) begin
        cfg_level = 2'($urandom_range(0, 3));
        cfg_ror   = 1'($urandom_range(0, 1));
        cfg_fair  = 1'($urandom_range(0, 1));
      end
      mst_req  = ($urandom_range(0, 99) < 30);
      iack_req = ($urandom_range(0, 99) < 20);
      lock     = ($urandom_range(0, 99) < 10);
      br_in    = ($urandom_range(0, 99) < 40) ? 4'($urandom) : 4'b0;
      bg_in    = ($urandom_range(0, 99) < 30) ? 4'($urandom) : 4'b0;
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule